// File: doc/BRIEF.md
# Presence-Gated Process Wrapper

This block wraps one dataflow compute function that has several input ports and several output ports. Every port owns a channel in a shared word store. Each stored word carries a presence flag in its top bit above the payload. A port keeps a channel base address, a fixed bound and a running index, and the address it touches is the base plus the index. The store is reached through a single request/acknowledge port, and one transaction is outstanding at a time.

When an activation tick arrives while the wrapper is idle, it reads the current word of every port, inputs first and then outputs. It fires only if every input word is flagged present and every output slot is flagged empty. A firing computes the results and writes them back: each output gets its result with the flag set, and each input gets its payload back with the flag cleared. After the final write is acknowledged, every index steps forward, wrapping at its bound. If the condition fails, nothing is written, the indices stay where they are, and a one-cycle stall pulse is raised. The compute function here is a stub: output k is the sum of all input payloads plus k, kept to the payload width.

Top module: `pgw_wrapper`

## Requirements
- R1: After reset the wrapper is idle with `st_req_o` and `stall_o` low, and every port index is zero, so the first activation touches each port's base address (port p has base p*16 with the default parameters; inputs are ports 0..NUM_IN-1 and outputs follow).
- R2: A tick while idle starts a read of every port at base plus index, in port order, inputs before outputs. Each read is issued only after the previous one is acknowledged.
- R3: When any input word has flag bit 31 clear, or any output word has flag bit 31 set, no write is issued and no index moves. `stall_o` goes high for exactly one cycle as the wrapper returns to idle.
- R4: On a firing, each output k is written with bit 31 set and bits 30:0 equal to the sum of all input payloads plus k, modulo 2^31.
- R5: On a firing, each input word is written back with bit 31 clear and the payload it held when read.
- R6: Writes follow all reads, go out in the same port order, and each waits for its acknowledge. No new activation can start until the final write is acknowledged.
- R7: After a firing, every port index advances by one and wraps to zero when it reaches that port's bound (default bounds 4, 3, 4, 2 for ports 0 to 3).
- R8: A tick that arrives while the wrapper is not idle is ignored, including a tick in the same cycle as the final write acknowledge.
- R9: While a request waits for its acknowledge, its address, direction and write data are held steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Activation tick |
| st_req_o | output | 1 | Storage request, held until acknowledged |
| st_we_o | output | 1 | 1 = write, 0 = read |
| st_addr_o | output | ADDR_W | Word address (port base plus index) |
| st_wdata_o | output | DATA_W+1 | Write word: presence flag in the top bit, payload below |
| st_ack_i | input | 1 | Acknowledge for the current request |
| st_rdata_i | input | DATA_W+1 | Read word, valid with the acknowledge |
| stall_o | output | 1 | One-cycle pulse when an activation finds its condition false |

## Verification
The sharp coincidence is the final write acknowledge, which returns the wrapper to idle, landing in the same cycle as a new activation tick. The bench's storage model raises a tick in exactly the cycle it acknowledges the last output write. Correct behaviour is judged by the transaction log: it must contain only that activation's eight transactions, and the request line must stay low afterwards. Ticks pulsed in the middle of an activation are judged the same way, and varied acknowledge latencies show that requests hold steady and that the port order is kept.

// File: rtl/pgw_pkg.sv
// Shared types for the presence-gated process wrapper.
package pgw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,  // waiting for an activation tick
        ST_REQ  = 2'd1,  // reading every port word in turn
        ST_EXEC = 2'd2,  // latching compute results
        ST_WR   = 2'd3   // writing every port word back in turn
    } pgw_state_e;
endpackage

// File: rtl/pgw_index_bank.sv
// Per-port running index with a modulo-bound step.
// Assumes: every bound in BOUNDS is between 1 and 2**IDX_W-1.
module pgw_index_bank #(
    parameter int NUM_PORTS = 4,
    parameter int IDX_W     = 3,
    parameter logic [NUM_PORTS*IDX_W-1:0] BOUNDS = '1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       adv_i,
    output logic [NUM_PORTS*IDX_W-1:0] idx_o
);
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        localparam logic [IDX_W-1:0] LAST = BOUNDS[p*IDX_W +: IDX_W] - 1'b1;
        logic [IDX_W-1:0] idx_q;
        // Step this port's index on a completed firing, wrapping at its bound.
        always_ff @(posedge clk) begin
            if (!rst_n)          idx_q <= '0;
            else if (adv_i)      idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
        end
        assign idx_o[p*IDX_W +: IDX_W] = idx_q;
    end
endmodule

// File: rtl/pgw_compute_stub.sv
// Placeholder compute function: output k = sum of inputs + k, truncated.
// Assumes: purely combinational; the wrapper latches its outputs.
module pgw_compute_stub #(
    parameter int NUM_IN  = 2,
    parameter int NUM_OUT = 2,
    parameter int DATA_W  = 31
) (
    input  logic [NUM_IN*DATA_W-1:0]  in_i,
    output logic [NUM_OUT*DATA_W-1:0] out_o
);
    logic [DATA_W-1:0] sum;
    // Accumulate all input payloads at payload width.
    always_comb begin
        sum = '0;
        for (int i = 0; i < NUM_IN; i++) sum = sum + in_i[i*DATA_W +: DATA_W];
    end
    for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
        assign out_o[k*DATA_W +: DATA_W] = sum + DATA_W'(k);
    end
endmodule

// File: rtl/pgw_wrapper.sv
// Presence-gated wrapper around one compute function.
// Reads every port word, fires only when inputs are present and output
// slots empty, writes results and consumed inputs back, then steps indices.
// Assumes: one storage transaction outstanding; ack may come any cycle
// after the request (including the first); port p has base p*CH_STRIDE.
module pgw_wrapper #(
    parameter int NUM_IN    = 2,
    parameter int NUM_OUT   = 2,
    parameter int DATA_W    = 31,
    parameter int ADDR_W    = 6,
    parameter int IDX_W     = 3,
    parameter int CH_STRIDE = 16,
    parameter logic [(NUM_IN+NUM_OUT)*IDX_W-1:0] BOUNDS = {3'd2, 3'd4, 3'd3, 3'd4}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    output logic              st_req_o,
    output logic              st_we_o,
    output logic [ADDR_W-1:0] st_addr_o,
    output logic [DATA_W:0]   st_wdata_o,
    input  logic              st_ack_i,
    input  logic [DATA_W:0]   st_rdata_i,
    output logic              stall_o
);
    import pgw_pkg::*;

    localparam int P      = NUM_IN + NUM_OUT;
    localparam int SLOT_W = (P > 1) ? $clog2(P) : 1;

    pgw_state_e               state;
    logic [SLOT_W-1:0]        slot;
    logic                     ok_q;
    logic [DATA_W-1:0]        rd_pay [P];
    logic [DATA_W-1:0]        wr_pay [P];
    logic [P*IDX_W-1:0]       idx_flat;
    logic [ADDR_W-1:0]        port_addr [P];
    logic [NUM_IN*DATA_W-1:0] cmp_in;
    logic [NUM_OUT*DATA_W-1:0] cmp_out;
    logic                     is_in, is_last, ok_now, adv;

    pgw_index_bank #(.NUM_PORTS(P), .IDX_W(IDX_W), .BOUNDS(BOUNDS)) u_idx (
        .clk(clk), .rst_n(rst_n), .adv_i(adv), .idx_o(idx_flat)
    );

    pgw_compute_stub #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .DATA_W(DATA_W)) u_cmp (
        .in_i(cmp_in), .out_o(cmp_out)
    );

    for (genvar p = 0; p < P; p++) begin : g_port
        assign port_addr[p] = ADDR_W'(p*CH_STRIDE) + ADDR_W'(idx_flat[p*IDX_W +: IDX_W]);
        if (p < NUM_IN) begin : g_in
            assign cmp_in[p*DATA_W +: DATA_W] = rd_pay[p];
            // Keep the consumed input payload for its write-back.
            always_ff @(posedge clk) begin
                if (state == ST_EXEC) wr_pay[p] <= rd_pay[p];
            end
        end else begin : g_out
            // Latch this output's compute result.
            always_ff @(posedge clk) begin
                if (state == ST_EXEC) wr_pay[p] <= cmp_out[(p-NUM_IN)*DATA_W +: DATA_W];
            end
        end
    end

    assign is_in      = (slot < SLOT_W'(NUM_IN));
    assign is_last    = (slot == SLOT_W'(P-1));
    assign ok_now     = is_in ? st_rdata_i[DATA_W] : ~st_rdata_i[DATA_W];
    assign st_req_o   = (state == ST_REQ) || (state == ST_WR);
    assign st_we_o    = (state == ST_WR);
    assign st_addr_o  = port_addr[slot];
    assign st_wdata_o = {~is_in, wr_pay[slot]};
    assign adv        = (state == ST_WR) && st_ack_i && is_last;

    // Capture each port's read payload as its acknowledge arrives.
    always_ff @(posedge clk) begin
        if (state == ST_REQ && st_ack_i) rd_pay[slot] <= st_rdata_i[DATA_W-1:0];
    end

    // Control sequence: idle -> reads -> execute -> writes -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            slot    <= '0;
            ok_q    <= 1'b1;
            stall_o <= 1'b0;
        end else begin
            stall_o <= 1'b0;
            case (state)
                ST_IDLE: if (tick_i) begin
                    state <= ST_REQ;
                    slot  <= '0;
                    ok_q  <= 1'b1;
                end
                ST_REQ: if (st_ack_i) begin
                    ok_q <= ok_q & ok_now;
                    if (is_last) begin
                        slot <= '0;
                        if (ok_q & ok_now) state <= ST_EXEC;
                        else begin
                            state   <= ST_IDLE;
                            stall_o <= 1'b1;
                        end
                    end else slot <= slot + 1'b1;
                end
                ST_EXEC: state <= ST_WR;
                ST_WR: if (st_ack_i) begin
                    if (is_last) begin
                        state <= ST_IDLE;
                        slot  <= '0;
                    end else slot <= slot + 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pgw_wrapper_chk.sv
// Protocol checker for pgw_wrapper, attached by bind.
// Assumes: port bases at p*CH_STRIDE, outputs above all inputs.
module pgw_wrapper_chk #(
    parameter int NUM_IN    = 2,
    parameter int DATA_W    = 31,
    parameter int ADDR_W    = 6,
    parameter int CH_STRIDE = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              st_req_o,
    input logic              st_we_o,
    input logic [ADDR_W-1:0] st_addr_o,
    input logic [DATA_W:0]   st_wdata_o,
    input logic              st_ack_i,
    input logic              stall_o
);
    localparam logic [ADDR_W-1:0] OUT_LO = ADDR_W'(NUM_IN*CH_STRIDE);

    a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_req_o && !st_ack_i) |=> (st_req_o && $stable(st_addr_o)
                                     && $stable(st_we_o) && $stable(st_wdata_o)));

    a_r3_stall_single: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |=> !stall_o);

    a_r3_stall_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |-> !st_req_o);

    a_r4_out_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        (st_req_o && st_we_o && st_addr_o >= OUT_LO) |-> st_wdata_o[DATA_W]);

    a_r5_in_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (st_req_o && st_we_o && st_addr_o < OUT_LO) |-> !st_wdata_o[DATA_W]);
endmodule

bind pgw_wrapper pgw_wrapper_chk #(
    .NUM_IN(NUM_IN), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CH_STRIDE(CH_STRIDE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .st_req_o(st_req_o), .st_we_o(st_we_o),
    .st_addr_o(st_addr_o), .st_wdata_o(st_wdata_o), .st_ack_i(st_ack_i),
    .stall_o(stall_o)
);

// File: tb/tb_pgw_wrapper.sv
// Bench for pgw_wrapper: vector table of firings, then directed cases.
module tb_pgw_wrapper;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_drv = 1'b0, tick_mem = 1'b0, tick;
    logic st_req, st_we, st_ack = 1'b0, stall;
    logic [5:0]  st_addr;
    logic [31:0] st_wdata, st_rdata = '0;

    assign tick = tick_drv | tick_mem;
    always #5 clk = ~clk;

    pgw_wrapper dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .st_req_o(st_req), .st_we_o(st_we),
        .st_addr_o(st_addr), .st_wdata_o(st_wdata), .st_ack_i(st_ack),
        .st_rdata_i(st_rdata), .stall_o(stall)
    );

    int checks = 0, fails = 0, done = 0;
    logic [31:0] mem [64];
    logic [5:0]  log_addr [64];
    logic        log_we   [64];
    logic [31:0] log_wd   [64];
    int log_n = 0, extra_wait = 0, wcnt = 0, stall_cnt = 0, stall_long = 0;
    logic tick_on_last = 1'b0, stall_prev = 1'b0;
    int exp_idx [4] = '{0, 0, 0, 0};
    int bnd     [4] = '{4, 3, 4, 2};

    // Storage model: acks after extra_wait cycles, logs each transaction.
    always @(negedge clk) begin
        tick_mem = 1'b0;
        if (stall) stall_cnt++;
        if (stall && stall_prev) stall_long++;
        stall_prev = stall;
        if (st_ack) st_ack = 1'b0;
        else if (st_req) begin
            if (wcnt < extra_wait) wcnt++;
            else begin
                wcnt = 0;
                st_ack = 1'b1;
                st_rdata = mem[st_addr];
                if (st_we) mem[st_addr] = st_wdata;
                if (log_n < 64) begin
                    log_addr[log_n] = st_addr; log_we[log_n] = st_we; log_wd[log_n] = st_wdata;
                end
                log_n++;
                if (st_we && st_addr >= 6'd48 && tick_on_last) tick_mem = 1'b1;  // R8 coincidence
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [5:0] paddr(input int p);
        return 6'(p*16 + exp_idx[p]);
    endfunction

    task automatic pulse_tick();
        @(negedge clk); tick_drv = 1'b1;
        @(negedge clk); tick_drv = 1'b0;
    endtask

    task automatic settle();
        repeat (80) @(negedge clk);
    endtask

    // One firing: load words, tick, check log order, stored words, index step.
    task automatic fire(input logic [30:0] a, input logic [30:0] b,
                        input logic [30:0] e0, input logic [30:0] e1, input int lat);
        extra_wait = lat;
        mem[paddr(0)] = {1'b1, a}; mem[paddr(1)] = {1'b1, b};
        mem[paddr(2)] = 32'h0;     mem[paddr(3)] = 32'h0;
        log_n = 0;
        pulse_tick();
        settle();
        chk("R6 transaction count", 32'(log_n), 32'd8);
        for (int i = 0; i < 8; i++) begin
            chk("R2/R6 port order address", 32'(log_addr[i]), 32'(paddr(i % 4)));
            chk("R2/R6 read-then-write", 32'(log_we[i]), 32'(i >= 4));
        end
        chk("R5 input 0 consumed", mem[paddr(0)], {1'b0, a});
        chk("R5 input 1 consumed", mem[paddr(1)], {1'b0, b});
        chk("R4 output 0 result", mem[paddr(2)], {1'b1, e0});
        chk("R4 output 1 result", mem[paddr(3)], {1'b1, e1});
        for (int p = 0; p < 4; p++) exp_idx[p] = (exp_idx[p] + 1) % bnd[p];  // R7
    endtask

    typedef struct packed {
        logic [30:0] a; logic [30:0] b; logic [30:0] e0; logic [30:0] e1; logic [1:0] lat;
    } vec_t;
    localparam vec_t VECS [6] = '{
        '{31'd1,          31'd2,  31'd3,          31'd4,          2'd0},
        '{31'd100,        31'd200,31'd300,        31'd301,        2'd2},
        '{31'h7FFFFFFF,   31'd1,  31'd0,          31'd1,          2'd1},
        '{31'h7FFFFFFE,   31'd0,  31'h7FFFFFFE,   31'h7FFFFFFF,   2'd0},
        '{31'd0,          31'd0,  31'd0,          31'd1,          2'd3},
        '{31'h12345678,   31'h11, 31'h12345689,   31'h1234568A,   2'd0}
    };

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 no request in reset", 32'(st_req), 32'd0);
        chk("R1 no stall in reset", 32'(stall), 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 idle without tick", 32'(st_req), 32'd0);

        // R4 R5 R7: vector table; six firings wrap every index
        for (int v = 0; v < 6; v++)
            fire(VECS[v].a, VECS[v].b, VECS[v].e0, VECS[v].e1, int'(VECS[v].lat));
        chk("R7 all indices wrapped", 32'(exp_idx[0]*1000 + exp_idx[1]*100 + exp_idx[2]*10 + exp_idx[3]),
            32'(2*1000 + 0*100 + 2*10 + 0));

        // R3: input 1 absent -> stall, no write, no index move
        extra_wait = 0;
        mem[paddr(0)] = {1'b1, 31'd7}; mem[paddr(1)] = {1'b0, 31'd9};
        mem[paddr(2)] = 32'h0; mem[paddr(3)] = 32'h0;
        log_n = 0; stall_cnt = 0; stall_long = 0;
        pulse_tick(); settle();
        chk("R3 only reads on missing input", 32'(log_n), 32'd4);
        chk("R3 stall pulse count", 32'(stall_cnt), 32'd1);
        chk("R3 stall one cycle", 32'(stall_long), 32'd0);
        chk("R3 input 0 untouched", mem[paddr(0)], {1'b1, 31'd7});
        // R3: output 0 slot still full -> stall
        mem[paddr(1)] = {1'b1, 31'd9}; mem[paddr(2)] = {1'b1, 31'd55};
        log_n = 0; stall_cnt = 0;
        pulse_tick(); settle();
        chk("R3 only reads on full output", 32'(log_n), 32'd4);
        chk("R3 stall on full output", 32'(stall_cnt), 32'd1);
        chk("R3 full output untouched", mem[paddr(2)], {1'b1, 31'd55});
        // R3 R7: a firing after stalls uses the unchanged indices
        fire(31'd7, 31'd9, 31'd16, 31'd17, 0);

        // R8: ticks during an activation are ignored
        mem[paddr(0)] = {1'b1, 31'd5}; mem[paddr(1)] = {1'b1, 31'd6};
        mem[paddr(2)] = 32'h0; mem[paddr(3)] = 32'h0;
        log_n = 0;
        pulse_tick();
        for (int i = 0; i < 3; i++) begin
            repeat (2) @(negedge clk);
            pulse_tick();
        end
        settle();
        chk("R8 mid-run ticks ignored", 32'(log_n), 32'd8);
        chk("R8 mid-run result", mem[paddr(2)], {1'b1, 31'd11});
        for (int p = 0; p < 4; p++) exp_idx[p] = (exp_idx[p] + 1) % bnd[p];

        // R8 R6: tick in the cycle of the final write acknowledge
        tick_on_last = 1'b1;
        fire(31'd20, 31'd22, 31'd42, 31'd43, 1);
        tick_on_last = 1'b0;
        chk("R8 no restart on final-ack tick", 32'(st_req), 32'd0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (done == 0) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule